// File: doc/BRIEF.md
# USB Controller Mode, Endian and Setup-Status Registers

This block is the small register set that a dual-role USB controller consults to decide how it behaves. It holds three things. The first is a two-bit controller-mode field. It can be written once after reset and then stays locked until the controller's soft reset clears it. The second is an endian-select bit. This bit drives a registered byte-lane swapper on the transfer-buffer data path. The third is a per-endpoint setup-status field. Each bit is set by a setup-received pulse from the protocol engine and cleared when software writes a 1 to it.

Software reaches the fields through a simple word-indexed register port. Writes take effect at the clock edge. Reads return data one cycle after the read strobe. The data-path side presents one 32-bit word per cycle, together with a flag that marks it as transfer-buffer payload. The block returns the same word one cycle later, with its bytes reversed when big-endian ordering is selected. Words that are not payload pass through unchanged. Examples are descriptor and setup-buffer words.

Top module: `usb_devctl_regs`

## Requirements
- R1: After the synchronous reset, the mode field is 00 (idle), endian select is 0, every setup-status bit is 0, and both registers read as 0.
- R2: The mode field sits in bits [1:0] of register index 0. The first write to that register after a reset stores those bits. Every later write leaves the mode unchanged until a reset.
- R3: A write of the reserved encoding 01 uses up the single allowed mode write, and the mode then reads back as 01. The other encodings are 10 for device and 11 for host.
- R4: A cycle with `ctl_rst` high returns the mode, endian select, setup status and read data to their reset values, and allows the mode to be written once again.
- R5: Endian select is bit 8 of register index 0. Every write to that register updates it, whether or not the mode is already locked.
- R6: A word with `buf_is_data` high appears on `buf_word_out` one cycle later. With endian select at 0 it is unchanged. With endian select at 1, input byte k is placed in output byte lane (3-k), so the first byte lands in the most significant lane.
- R7: A word with `buf_is_data` low appears on `buf_word_out` one cycle later and unchanged, whatever the value of endian select.
- R8: A pulse on `setup_evt[i]` sets setup-status bit i only while the mode is 10 (device). In any other mode the pulse is ignored.
- R9: The setup-status bits are bits [3:0] of register index 1. Writing 1 to a bit clears it, and writing 0 leaves it as it is.
- R10: When a setup pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R11: Bits [31:4] of register index 1 always read as 0, and writes to them have no effect. Unused bits of register index 0 also read as 0.
- R12: `reg_rdata` takes the addressed register's value one cycle after `reg_rd` and holds it until the next read. Register indices other than 0 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_rst | input | 1 | Controller soft reset command, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data |
| setup_evt | input | NUM_EP | Per-endpoint setup-received pulses |
| buf_word_in | input | DATA_W | Data-path word in |
| buf_is_data | input | 1 | Marks the word as transfer-buffer payload |
| buf_word_out | output | DATA_W | Data-path word out, byte order applied |
| ctl_mode | output | 2 | Current controller mode |
| endian_sel | output | 1 | Current endian select |

## Verification
The bench builds the block with its default parameters: four endpoints, 32-bit register and data words, and a 4-bit register index. With these values every setup-status bit, every byte lane of the swapper and the unmapped register indices can all be driven directly. Because there are only four lanes, the byte reversal can be checked exactly, and the write-1-to-clear and set-wins cases can be exercised on all four endpoints. A small register index also keeps out-of-range reads reachable.

// File: rtl/usbdc_pkg.sv
package usbdc_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_DEV  = 2'b10,
    MODE_HOST = 2'b11
  } ctl_mode_e;

  localparam int CTRL_IDX   = 0;
  localparam int SETUP_IDX  = 1;
  localparam int ENDIAN_BIT = 8;
endpackage

// File: rtl/mode_lock_reg.sv
module mode_lock_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_rst,
  input  logic       wr_ctrl,
  input  logic [1:0] wr_mode,
  input  logic       wr_endian,
  output logic [1:0] mode_q,
  output logic       endian_q,
  output logic       locked_q
);
  always_ff @(posedge clk) begin
    if (rst || ctl_rst) begin
      mode_q   <= usbdc_pkg::MODE_IDLE;
      endian_q <= 1'b0;
      locked_q <= 1'b0;
    end else if (wr_ctrl) begin
      endian_q <= wr_endian;
      if (!locked_q) begin
        mode_q   <= wr_mode;
        locked_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/setup_stat_reg.sv
module setup_stat_reg #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_rst,
  input  logic              dev_mode,
  input  logic [NUM_EP-1:0] evt,
  input  logic [NUM_EP-1:0] clr_mask,
  output logic [NUM_EP-1:0] stat_q
);
  logic [NUM_EP-1:0] set_mask;
  assign set_mask = dev_mode ? evt : '0;

  always_ff @(posedge clk) begin
    if (rst || ctl_rst) stat_q <= '0;
    else                stat_q <= (stat_q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/byte_lane_swap.sv
module byte_lane_swap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_rst,
  input  logic              big_end,
  input  logic              is_buf,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;
  logic [DATA_W-1:0] swapped;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign swapped[8*k +: 8] = din[8*(LANES-1-k) +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_rst)      dout <= '0;
    else if (is_buf && big_end) dout <= swapped;
    else                     dout <= din;
  end
endmodule

// File: rtl/usb_devctl_regs.sv
module usb_devctl_regs #(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 32,
  parameter int DATA_W = 32,
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_EP-1:0] setup_evt,
  input  logic [DATA_W-1:0] buf_word_in,
  input  logic              buf_is_data,
  output logic [DATA_W-1:0] buf_word_out,
  output logic [1:0]        ctl_mode,
  output logic              endian_sel
);
  import usbdc_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(SETUP_IDX);

  logic              hit_ctrl, hit_setup;
  logic              mode_locked;
  logic [NUM_EP-1:0] setup_q;
  logic [NUM_EP-1:0] clr_mask;
  logic [REG_W-1:0]  rd_mux;

  assign hit_ctrl  = reg_addr == A_CTRL;
  assign hit_setup = reg_addr == A_SETUP;
  assign clr_mask  = (reg_wr && hit_setup) ? reg_wdata[NUM_EP-1:0] : '0;

  mode_lock_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .ctl_rst   (ctl_rst),
    .wr_ctrl   (reg_wr && hit_ctrl),
    .wr_mode   (reg_wdata[1:0]),
    .wr_endian (reg_wdata[ENDIAN_BIT]),
    .mode_q    (ctl_mode),
    .endian_q  (endian_sel),
    .locked_q  (mode_locked)
  );

  setup_stat_reg #(.NUM_EP(NUM_EP)) u_setup (
    .clk      (clk),
    .rst      (rst),
    .ctl_rst  (ctl_rst),
    .dev_mode (ctl_mode == MODE_DEV),
    .evt      (setup_evt),
    .clr_mask (clr_mask),
    .stat_q   (setup_q)
  );

  byte_lane_swap #(.DATA_W(DATA_W)) u_swap (
    .clk     (clk),
    .rst     (rst),
    .ctl_rst (ctl_rst),
    .big_end (endian_sel),
    .is_buf  (buf_is_data),
    .din     (buf_word_in),
    .dout    (buf_word_out)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[1:0]        = ctl_mode;
      rd_mux[ENDIAN_BIT] = endian_sel;
    end else if (hit_setup) begin
      rd_mux[NUM_EP-1:0] = setup_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_rst) reg_rdata <= '0;
    else if (reg_rd)    reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/usbdc_regs_chk.sv
module usbdc_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 32,
  parameter int DATA_W = 32,
  parameter int NUM_EP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NUM_EP-1:0] setup_evt,
  input logic [DATA_W-1:0] buf_word_in,
  input logic              buf_is_data,
  input logic [DATA_W-1:0] buf_word_out,
  input logic [1:0]        ctl_mode,
  input logic              endian_sel,
  input logic              mode_locked,
  input logic [NUM_EP-1:0] setup_q
);
  localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(usbdc_pkg::SETUP_IDX);

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (mode_locked && !ctl_rst) |=> $stable(ctl_mode)); // R2

  AST_CTL_RESET: assert property (@(posedge clk) disable iff (rst)
    ctl_rst |=> (ctl_mode == 2'b00 && !endian_sel && setup_q == '0 && !mode_locked)); // R4

  AST_PASS_NONBUF: assert property (@(posedge clk) disable iff (rst)
    (!buf_is_data && !ctl_rst) |=> (buf_word_out == $past(buf_word_in))); // R7

  AST_SETUP_GATED: assert property (@(posedge clk) disable iff (rst)
    (ctl_mode != 2'b10) |=> ((setup_q & ~$past(setup_q)) == '0)); // R8

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_SETUP && !ctl_rst)
    |=> ((setup_q & $past(reg_wdata[NUM_EP-1:0]) & ~$past(setup_evt)) == '0)); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (ctl_mode == 2'b10 && !ctl_rst) |=> ((setup_q & $past(setup_evt)) == $past(setup_evt))); // R10

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_SETUP && !ctl_rst) |=> (reg_rdata[REG_W-1:NUM_EP] == '0)); // R11
endmodule

bind usb_devctl_regs usbdc_regs_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .NUM_EP(NUM_EP)
) u_chk (
  .clk(clk), .rst(rst), .ctl_rst(ctl_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .setup_evt(setup_evt), .buf_word_in(buf_word_in), .buf_is_data(buf_is_data),
  .buf_word_out(buf_word_out), .ctl_mode(ctl_mode), .endian_sel(endian_sel),
  .mode_locked(mode_locked), .setup_q(setup_q)
);

// File: tb/sim_usb_devctl_regs.sv
`timescale 1ns/1ps
module sim_usb_devctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_rst = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  setup_evt = '0;
  logic [31:0] buf_word_in = '0;
  logic        buf_is_data = 1'b0;
  logic [31:0] buf_word_out;
  logic [1:0]  ctl_mode;
  logic        endian_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  usb_devctl_regs u0 (
    .clk(clk), .rst(rst), .ctl_rst(ctl_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .setup_evt(setup_evt), .buf_word_in(buf_word_in), .buf_is_data(buf_is_data),
    .buf_word_out(buf_word_out), .ctl_mode(ctl_mode), .endian_sel(endian_sel)
  );

  always #4 clk = ~clk;

  // Behavioural reference model
  int unsigned m_mode = 0, m_end = 0, m_stat = 0, m_rd = 0, m_dp = 0;
  bit m_lock = 0;

  always @(posedge clk) begin
    int unsigned n_mode, n_end, n_stat, n_rd, n_dp, rv;
    bit n_lock;
    n_mode = m_mode; n_end = m_end; n_stat = m_stat; n_rd = m_rd; n_lock = m_lock;
    if (buf_is_data && m_end == 1)
      n_dp = {buf_word_in[7:0], buf_word_in[15:8], buf_word_in[23:16], buf_word_in[31:24]};
    else
      n_dp = buf_word_in;
    if (reg_rd) begin
      if (reg_addr == 0)      rv = m_mode + m_end * 256;
      else if (reg_addr == 1) rv = m_stat;
      else                    rv = 0;
      n_rd = rv;
    end
    if (reg_wr && reg_addr == 0) begin
      n_end = reg_wdata[8];
      if (!m_lock) begin n_mode = reg_wdata[1:0]; n_lock = 1; end
    end
    if (reg_wr && reg_addr == 1) n_stat = n_stat & ~int'(reg_wdata[3:0]);
    if (m_mode == 2) n_stat = n_stat | setup_evt;
    if (rst || ctl_rst) begin
      n_mode = 0; n_end = 0; n_stat = 0; n_rd = 0; n_lock = 0;
      n_dp = (rst || ctl_rst) ? 0 : n_dp;
    end
    m_mode = n_mode; m_end = n_end; m_stat = n_stat; m_rd = n_rd; m_dp = n_dp; m_lock = n_lock;
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 mode vs model", ctl_mode, m_mode);
      chk("R5 endian vs model", endian_sel, m_end);
      chk("R6 data path vs model", buf_word_out, m_dp);
      chk("R12 read data vs model", reg_rdata, m_rd);
    end
  end

  task automatic wr(int idx, logic [31:0] d);
    reg_addr = idx[3:0]; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int idx, output logic [31:0] v);
    reg_addr = idx[3:0]; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic pulse_ctl_rst();
    ctl_rst = 1;
    @(negedge clk);
    ctl_rst = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode after reset", ctl_mode, 0);
    chk("R1 endian after reset", endian_sel, 0);
    rd(0, v); chk("R1 ctrl reads 0", v, 0);
    rd(1, v); chk("R1 status reads 0", v, 0);

    // R8 events ignored in idle
    setup_evt = 4'hF; @(negedge clk); setup_evt = 0;
    rd(1, v); chk("R8 idle ignores setup", v, 0);

    // R3 reserved code locks; R2 second write ignored
    wr(0, 32'h1);
    rd(0, v); chk("R3 reserved reads back", v, 32'h1);
    wr(0, 32'h2);
    rd(0, v); chk("R2 locked mode unchanged", v, 32'h1);

    // R4 controller reset reopens
    pulse_ctl_rst();
    rd(0, v); chk("R4 ctl reset clears mode", v, 0);
    wr(0, 32'h102);
    rd(0, v); chk("R2 write after ctl reset", v, 32'h102);
    wr(0, 32'h003);
    rd(0, v); chk("R5 endian writable while locked", v, 32'h002);

    // R6 / R7 swapping
    buf_is_data = 1; buf_word_in = 32'h11223344;
    @(negedge clk); chk("R6 little endian pass", buf_word_out, 32'h11223344);
    wr(0, 32'h100);
    buf_word_in = 32'hA1B2C3D4;
    @(negedge clk); chk("R6 big endian swap", buf_word_out, 32'hD4C3B2A1);
    buf_is_data = 0; buf_word_in = 32'h0BADF00D;
    @(negedge clk); chk("R7 descriptor unswapped", buf_word_out, 32'h0BADF00D);

    // R8 device mode sets, R9 w1c
    setup_evt = 4'b0101; @(negedge clk); setup_evt = 0;
    rd(1, v); chk("R8 device mode sets", v, 5);
    wr(1, 32'h1);
    rd(1, v); chk("R9 w1c clears bit0", v, 4);
    wr(1, 32'hFFFF_FFF0);
    rd(1, v); chk("R11 upper write no effect", v, 4);
    rd(7, v); chk("R12 unmapped index reads 0", v, 0);

    // R10 set wins
    setup_evt = 4'b1100; wr(1, 32'hC); setup_evt = 0;
    rd(1, v); chk("R10 set wins over clear", v, 32'hC);
    wr(1, 32'hF);
    rd(1, v); chk("R9 clear all", v, 0);

    // R4 controller reset clears status and endian
    setup_evt = 4'b0010; @(negedge clk); setup_evt = 0;
    pulse_ctl_rst();
    rd(1, v); chk("R4 status cleared", v, 0);
    chk("R4 endian cleared", endian_sel, 0);

    // R8 host mode ignores events
    wr(0, 32'h3);
    setup_evt = 4'hF; @(negedge clk); setup_evt = 0;
    rd(1, v); chk("R8 host ignores setup", v, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule